// File: doc/BRIEF.md
# Dual-Read-Port Register File

This block is a tiny register file: a handful of words, one write port and two read ports that work independently of each other. A write is synchronous. It happens on the rising clock edge and only when the write enable is high. The write address chooses the one word that takes the data.

Each read port has its own address and its own output bus. The read path is purely combinational, so a bus shows the addressed word with no clock involved. Either port may address any word, and both ports may address the same word. Each bus has its own enable. When that enable is low, the bus floats to high impedance at once, with no dependence on the clock. Several instances may therefore share bus wiring, provided that only one of them drives a given bus at a time.

A synchronous active-low reset clears every word. Word count and word width are parameters and default to four words of four bits. Cascading for wider or deeper storage is done outside the block.

Top module: `rf_dual_read`

## Requirements
- R1: The block holds WORDS words of WIDTH bits (default 4 x 4). Words are numbered 0 to WORDS-1, and the binary address value selects the word of that number.
- R2: When `wr_en` is 1 at a rising edge of `clk`, `wr_data` is stored into word `wr_addr`. No other word changes.
- R3: When `wr_en` is 0 at a rising edge, no word changes, whatever `wr_addr` and `wr_data` hold.
- R4: While a bus is enabled, it shows the word at its own read address. The value changes as soon as the address changes, with no clock edge.
- R5: Ports A and B read at the same time and independently. When both select the same word, both buses show that word.
- R6: When a bus enable is 0, that bus is high impedance (all bits z) immediately, between clock edges too. When the enable is 1, the bus drives.
- R7: A read of the word being written shows the old contents until the rising edge and the new contents after it.
- R8: When `rst_n` is 0 at a rising edge, every word becomes 0. This reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear of all words |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 2 | Word written on the edge |
| wr_data | input | 4 | Data to store |
| rd_addr_a | input | 2 | Word shown on bus A |
| rd_addr_b | input | 2 | Word shown on bus B |
| bus_en_a | input | 1 | 1 = bus A drives, 0 = bus A high impedance |
| bus_en_b | input | 1 | 1 = bus B drives, 0 = bus B high impedance |
| bus_a | output | 4 | Read bus A, tri-state |
| bus_b | output | 4 | Read bus B, tri-state |

## Verification
The bench samples each bus just before and just after every rising edge. This catches a read path that was wrongly registered: such a design would lag one cycle behind an address change. It also catches a write that takes effect early, which would break the old-then-new behaviour of R7. Cycles with the write enable low carry changing write addresses and data, so a design that writes without checking the enable would corrupt words. The bench toggles the enables and sets both ports to the same address, which exposes swapped or shared select logic and enables that wait for a clock edge. A reset arrives together with a pending write, so a design that gives the write priority over the reset leaves a nonzero word.

// File: rtl/rf_pkg.sv
// Package: shared defaults for the dual-read register file.
// Assumes: word count is a power of two.
package rf_pkg;
    localparam int DEF_WORDS = 4;
    localparam int DEF_WIDTH = 4;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/rf_store.sv
// Module: word storage with a decoded synchronous write port and clear.
// Assumes: wr_addr and wr_data are stable around the rising edge.
module rf_store #(
    parameter int WORDS = rf_pkg::DEF_WORDS,
    parameter int WIDTH = rf_pkg::DEF_WIDTH,
    localparam int AW = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WORDS-1:0][WIDTH-1:0]  words
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Purpose: load this word when it is addressed and writing is on.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                words[g] <= wr_data;
        end

        // Checks that a write to another address leaves this word alone.
        assert_other_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr != AW'(g))) |=> $stable(words[g]));
    end

    // Checks that a disabled write leaves all of the storage unchanged.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));
endmodule

// File: rtl/rf_read_port.sv
// Module: one combinational read port with a tri-state output bus.
// Assumes: no other driver is enabled on the same net while this one drives.
module rf_read_port #(
    parameter int WORDS = rf_pkg::DEF_WORDS,
    parameter int WIDTH = rf_pkg::DEF_WIDTH,
    localparam int AW = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][WIDTH-1:0]  words,
    input  logic [AW-1:0]                rd_addr,
    input  logic                         bus_en,
    output logic [WIDTH-1:0]             bus
);
    logic [WIDTH-1:0] sel_word;

    // Purpose: choose the addressed word, with no clock involved.
    always_comb sel_word = words[rd_addr];

    // Purpose: drive the bus or release it to high impedance.
    assign bus = bus_en ? sel_word : {WIDTH{1'bz}};
endmodule

// File: rtl/rf_dual_read.sv
// Module: top of the register file, one write port and two read ports.
// Assumes: the caller drives the write inputs away from the active edge.
module rf_dual_read #(
    parameter int WORDS = rf_pkg::DEF_WORDS,
    parameter int WIDTH = rf_pkg::DEF_WIDTH,
    localparam int AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    input  logic             bus_en_a,
    input  logic             bus_en_b,
    output logic [WIDTH-1:0] bus_a,
    output logic [WIDTH-1:0] bus_b
);
    localparam int NP = rf_pkg::NUM_PORTS;

    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [NP-1:0][AW-1:0]       port_addr;
    logic [NP-1:0]               port_en;
    logic [NP-1:0][WIDTH-1:0]    port_bus;

    rf_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .words(words)
    );

    // Purpose: collect the per-port controls into arrays.
    always_comb begin
        port_addr = {rd_addr_b, rd_addr_a};
        port_en   = {bus_en_b, bus_en_a};
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        rf_read_port #(.WORDS(WORDS), .WIDTH(WIDTH)) u_port (
            .words(words), .rd_addr(port_addr[p]),
            .bus_en(port_en[p]), .bus(port_bus[p])
        );
    end

    assign bus_a = port_bus[0];
    assign bus_b = port_bus[1];

    // Checks that a word written on the last edge is visible on bus A.
    assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && bus_en_a && (rd_addr_a == $past(wr_addr)))
            |-> (bus_a == $past(wr_data)));

    // Checks that two enabled ports on the same word agree.
    assert_same_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_a && bus_en_b && (rd_addr_a == rd_addr_b)) |-> (bus_a == bus_b));
endmodule

// File: tb/rf_dual_read_tb.sv
module rf_dual_read_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int N = 4;

    logic clk = 0, rst_n = 0, wr_en = 0, en_a = 0, en_b = 0;
    logic [1:0] wa = 0, ra_a = 0, ra_b = 0;
    logic [W-1:0] wd = 0;
    logic [W-1:0] bus_a, bus_b;
    logic [W-1:0] model [N];
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_dual_read u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd),
        .rd_addr_a(ra_a), .rd_addr_b(ra_b), .bus_en_a(en_a), .bus_en_b(en_b),
        .bus_a(bus_a), .bus_b(bus_b)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_buses(string req);
        check({req, " bus A"}, bus_a, en_a ? model[ra_a] : {W{1'bz}});
        check({req, " bus B"}, bus_b, en_b ? model[ra_b] : {W{1'bz}});
    endtask

    // One cycle: drive at the falling edge, check before and after the rising edge.
    task automatic cyc(string req, logic r, logic we, logic [1:0] a, logic [W-1:0] d,
                       logic [1:0] ra, logic [1:0] rb, logic ea, logic eb);
        @(negedge clk);
        rst_n = r; wr_en = we; wa = a; wd = d; ra_a = ra; ra_b = rb; en_a = ea; en_b = eb;
        #1 check_buses(req);
        @(posedge clk);
        if (!r) for (int i = 0; i < N; i++) model[i] = '0;
        else if (we) model[a] = d;
        #1 check_buses(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        // R8: reset clears all words, and it takes priority over a write.
        @(posedge clk); #1;
        cyc("R8", 0, 1, 2'd1, 4'hF, 2'd0, 2'd1, 0, 0);
        for (int i = 0; i < N; i++) cyc("R8", 1, 0, 2'd0, 4'h0, 2'(i), 2'(N-1-i), 1, 1);
        // R1 R2: fill every word, with each port reading back.
        for (int i = 0; i < N; i++) cyc("R2", 1, 1, 2'(i), 4'(4'hA + i), 2'(i), 2'(i), 1, 1);
        for (int i = 0; i < N; i++) cyc("R1", 1, 0, 2'd3, 4'h0, 2'(i), 2'(i ^ 1), 1, 1);
        // R3: disabled writes with changing address and data.
        for (int i = 0; i < N; i++) cyc("R3", 1, 0, 2'(i), 4'(~i), 2'(i), 2'(i), 1, 1);
        // R7: read the word being written, on both ports.
        cyc("R7", 1, 1, 2'd2, 4'h5, 2'd2, 2'd2, 1, 1);
        cyc("R7", 1, 1, 2'd2, 4'h9, 2'd2, 2'd0, 1, 1);
        // R5: same address on both ports, then different.
        cyc("R5", 1, 0, 2'd0, 4'h0, 2'd3, 2'd3, 1, 1);
        cyc("R5", 1, 0, 2'd0, 4'h0, 2'd0, 2'd3, 1, 1);
        // R6: enables switched between edges and checked without a clock.
        cyc("R6", 1, 0, 2'd0, 4'h0, 2'd1, 2'd2, 0, 1);
        cyc("R6", 1, 0, 2'd0, 4'h0, 2'd1, 2'd2, 1, 0);
        @(negedge clk);
        #1 en_a = 0; en_b = 1; #1 check_buses("R6 async");
        #1 en_a = 1; en_b = 0; #1 check_buses("R6 async");
        // R4: address changes between edges, seen at once.
        #1 en_b = 1; ra_a = 2'd0; ra_b = 2'd1; #1 check_buses("R4 comb");
        #1 ra_a = 2'd3; ra_b = 2'd2; #1 check_buses("R4 comb");
        // Mixed traffic on every input against the model.
        for (int k = 0; k < 400; k++)
            cyc("R2/R4/R6", 1, 1'($urandom), 2'($urandom), 4'($urandom), 2'($urandom),
                2'($urandom), 1'($urandom), 1'($urandom));
        // R8: a reset after data is present.
        cyc("R8", 0, 0, 2'd0, 4'h0, 2'd1, 2'd2, 1, 1);
        for (int i = 0; i < N; i++) cyc("R8", 1, 0, 2'd0, 4'h0, 2'(i), 2'(i), 1, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule